// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a synchronous DRAM from reset until the memory is ready for normal traffic. Out of reset it holds the clock-enable pin high and drives only no-operation commands for a settle period. The period is given as a clock count so that a simulation can shorten it. It then walks the mandatory start-up order: one precharge of all banks, a programmable number of auto-refresh commands, a write of the normal mode register and, when enabled, a write of the extended mode register. Each command is followed by a parameterized gap in which only no-ops are driven.

The mode words are assembled from configuration inputs: CAS latency, burst length code, burst ordering, write-burst mode, output drive strength and the partial-array refresh size. One cycle after the last gap expires the block raises its done flag. From then on it parks the bus at no-op with a zero address, so a main controller can take over the pins. The flag stays high until the next reset. An asynchronous reset at any point aborts the sequence and restarts it from the beginning.

Top module: `sdram_boot_seq`

## Requirements
- R1: While `rst_n` is low the outputs are `sd_cke`=1, a no-op command (`sd_cs_n`,`sd_ras_n`,`sd_cas_n`,`sd_we_n` = 0,1,1,1), `sd_ba`=0, `sd_addr`=0 and `init_done`=0.
- R2: `sd_cke` is 1 in every cycle, during and after reset.
- R3: After reset is released, the first command other than a no-op is driven after the SETTLE_CYC-th rising clock edge. Until then every cycle shows a no-op with zero address and bank.
- R4: That first command is a precharge of all banks: pins 0,0,1,0, address bit 10 set, all other address bits and the bank at zero.
- R5: NUM_REF auto-refresh commands follow (pins 0,0,0,1, zero address and bank). The first comes TRP_CYC edges after the precharge, and each later command comes TRC_CYC edges after a refresh. Every cycle in between shows a no-op with zero address and bank.
- R6: After the last refresh gap, a normal mode write is driven (pins 0,0,0,0, bank 00). Address bits 2..0 carry `cfg_burst_len` unchanged, bit 3 carries `cfg_burst_ilv`, bits 6..4 are {0,`cfg_cas_lat`}, bit 9 carries `cfg_wr_single`, and bits 8, 7 and 12..10 are 0.
- R7: When `cfg_ext_en` is 1, an extended mode write comes TMRD_CYC edges after the normal one (pins 0,0,0,0, bank 10). Address bits 2..0 carry `cfg_pasr`, bits 6..5 carry `cfg_drive`, and all other bits are 0.
- R8: When `cfg_ext_en` is 0, no extended write is driven, `cfg_drive` and `cfg_pasr` have no effect on any output, and `init_done` rises TMRD_CYC edges after the normal mode write.
- R9: After the last mode write, exactly TMRD_CYC-1 no-op cycles follow. `init_done` rises on the next edge, and while it is high the bus shows a no-op with zero address and bank.
- R10: `init_done` stays high until reset. Asserting `rst_n` low at any time returns all outputs to the R1 state at once, and release restarts the full sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cas_lat | input | 2 | CAS latency in clocks (1, 2 or 3) |
| cfg_burst_len | input | 3 | Burst length code placed in the mode word |
| cfg_burst_ilv | input | 1 | 1 selects interleaved burst ordering |
| cfg_wr_single | input | 1 | 1 selects single-location writes |
| cfg_drive | input | 2 | Output drive strength code for the extended word |
| cfg_pasr | input | 3 | Refreshed array portion code (000 full, 001 half, 010 quarter) |
| cfg_ext_en | input | 1 | 1 issues the extended mode write |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Initialization complete, bus free for the main controller |

## Verification
Two events can land in the same cycle: a refresh command on the bus and an asynchronous reset. The bench provokes this by pulling `rst_n` low in the very cycle a refresh is driven. It then requires the outputs to return to the idle reset state before the next edge, and requires the following release to replay the whole sequence from its first no-op. The other coincidence is the last mode gap expiring in the same cycle that `init_done` rises. It is judged by comparing every cycle against a bench model that builds the expected pin values slot by slot from the requirements.

// File: rtl/sdram_boot_pkg.sv
package sdram_boot_pkg;

   // command pins in the order {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MRS = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_NOP = 4'b0111
   } sdr_cmd_e;

   typedef enum logic [3:0] {
      PH_SETTLE,
      PH_PRE,
      PH_PRE_GAP,
      PH_REF,
      PH_REF_GAP,
      PH_MODE,
      PH_MODE_GAP,
      PH_XMODE,
      PH_XMODE_GAP,
      PH_READY
   } boot_phase_e;

   localparam int MODE_W = 13;

   typedef struct packed {
      logic [1:0] cas_lat;
      logic [2:0] burst_len;
      logic       burst_ilv;
      logic       wr_single;
      logic [1:0] drive;
      logic [2:0] pasr;
   } boot_cfg_t;

endpackage

// File: rtl/boot_gap_timer.sv
module boot_gap_timer #(
   parameter int CNT_W   = 8,
   parameter int RST_VAL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             cnt_zero
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= CNT_W'(RST_VAL);
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign cnt_zero = (cnt == '0);

   // once expired the timer stays expired until reloaded (R3 settle window)
   p_zero_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_zero && !load) |=> cnt_zero);

endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
   import sdram_boot_pkg::*;
#(
   parameter int TRP_CYC  = 3,
   parameter int TRC_CYC  = 9,
   parameter int TMRD_CYC = 2,
   parameter int NUM_REF  = 2,
   parameter int CNT_W    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_en,
   input  logic             gap_zero,
   output boot_phase_e      phase,
   output logic             load,
   output logic [CNT_W-1:0] load_val
);

   localparam int RC_W = $clog2(NUM_REF + 1);

   boot_phase_e     phase_nxt;
   logic [RC_W-1:0] ref_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_SETTLE;
         ref_cnt <= '0;
      end else begin
         phase <= phase_nxt;
         if (phase == PH_REF)
            ref_cnt <= ref_cnt + 1'b1;
      end
   end

   always_comb begin
      phase_nxt = phase;
      load      = 1'b0;
      load_val  = '0;
      case (phase)
         PH_SETTLE:    if (gap_zero) phase_nxt = PH_PRE;
         PH_PRE: begin
            phase_nxt = PH_PRE_GAP;
            load      = 1'b1;
            load_val  = CNT_W'(TRP_CYC - 2);
         end
         PH_PRE_GAP:   if (gap_zero) phase_nxt = PH_REF;
         PH_REF: begin
            phase_nxt = PH_REF_GAP;
            load      = 1'b1;
            load_val  = CNT_W'(TRC_CYC - 2);
         end
         PH_REF_GAP:
            if (gap_zero)
               phase_nxt = (ref_cnt == RC_W'(NUM_REF)) ? PH_MODE : PH_REF;
         PH_MODE: begin
            phase_nxt = PH_MODE_GAP;
            load      = 1'b1;
            load_val  = CNT_W'(TMRD_CYC - 2);
         end
         PH_MODE_GAP:
            if (gap_zero) phase_nxt = ext_en ? PH_XMODE : PH_READY;
         PH_XMODE: begin
            phase_nxt = PH_XMODE_GAP;
            load      = 1'b1;
            load_val  = CNT_W'(TMRD_CYC - 2);
         end
         PH_XMODE_GAP: if (gap_zero) phase_nxt = PH_READY;
         PH_READY:     phase_nxt = PH_READY;
         default:      phase_nxt = PH_SETTLE;
      endcase
   end

   // the mode write only starts once every refresh has been counted (R5)
   p_refs_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_MODE) |-> (ref_cnt == RC_W'(NUM_REF)));

   // the ready phase is terminal until reset (R10)
   p_ready_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_READY) |=> (phase == PH_READY));

endmodule

// File: rtl/boot_cmd_enc.sv
module boot_cmd_enc
   import sdram_boot_pkg::*;
#(
   parameter int ADDR_W = 13,
   parameter int BA_W   = 2
) (
   input  boot_phase_e       phase,
   input  boot_cfg_t         cfg,
   output logic [3:0]        cmd,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr,
   output logic              ready
);

   logic [MODE_W-1:0] word;
   logic [1:0]        ba_w;

   always_comb begin
      cmd   = CMD_NOP;
      word  = '0;
      ba_w  = 2'b00;
      ready = 1'b0;
      case (phase)
         PH_PRE: begin
            cmd      = CMD_PRE;
            word[10] = 1'b1;
         end
         PH_REF:  cmd = CMD_REF;
         PH_MODE: begin
            cmd       = CMD_MRS;
            word[2:0] = cfg.burst_len;
            word[3]   = cfg.burst_ilv;
            word[6:4] = {1'b0, cfg.cas_lat};
            word[9]   = cfg.wr_single;
         end
         PH_XMODE: begin
            cmd       = CMD_MRS;
            ba_w      = 2'b10;
            word[2:0] = cfg.pasr;
            word[6:5] = cfg.drive;
         end
         PH_READY: ready = 1'b1;
         default:  cmd = CMD_NOP;
      endcase
   end

   generate
      if (ADDR_W > MODE_W) begin : g_addr_pad
         assign addr = {{(ADDR_W - MODE_W){1'b0}}, word};
      end else if (ADDR_W == MODE_W) begin : g_addr_eq
         assign addr = word;
      end else begin : g_addr_cut
         assign addr = word[ADDR_W-1:0];
      end

      if (BA_W > 2) begin : g_ba_pad
         assign ba = {{(BA_W - 2){1'b0}}, ba_w};
      end else begin : g_ba_eq
         assign ba = ba_w;
      end
   endgenerate

endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
   import sdram_boot_pkg::*;
#(
   parameter int ADDR_W     = 13,
   parameter int BA_W       = 2,
   parameter int SETTLE_CYC = 26667,
   parameter int TRP_CYC    = 3,
   parameter int TRC_CYC    = 9,
   parameter int TMRD_CYC   = 2,
   parameter int NUM_REF    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_cas_lat,
   input  logic [2:0]        cfg_burst_len,
   input  logic              cfg_burst_ilv,
   input  logic              cfg_wr_single,
   input  logic [1:0]        cfg_drive,
   input  logic [2:0]        cfg_pasr,
   input  logic              cfg_ext_en,
   output logic              sd_cke,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [BA_W-1:0]   sd_ba,
   output logic [ADDR_W-1:0] sd_addr,
   output logic              init_done
);

   localparam int GAP_A   = (TRP_CYC > TRC_CYC) ? TRP_CYC : TRC_CYC;
   localparam int GAP_B   = (GAP_A > TMRD_CYC) ? GAP_A : TMRD_CYC;
   localparam int MAX_CNT = (SETTLE_CYC > GAP_B) ? SETTLE_CYC : GAP_B;
   localparam int CNT_W   = $clog2(MAX_CNT + 1);

   generate
      if (ADDR_W < 11) begin : g_bad_addr
         $error("ADDR_W must reach bit 10 for precharge-all");
      end
      if (BA_W < 2) begin : g_bad_ba
         $error("BA_W must be at least 2");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("SETTLE_CYC must be at least 1");
      end
      if (TRP_CYC < 2 || TRC_CYC < 2) begin : g_bad_gap
         $error("TRP_CYC and TRC_CYC must be at least 2");
      end
      if (TMRD_CYC < 2) begin : g_bad_mrd
         $error("TMRD_CYC must be at least 2");
      end
      if (NUM_REF < 2) begin : g_bad_ref
         $error("NUM_REF must be at least 2");
      end
   endgenerate

   boot_phase_e      phase;
   logic             load;
   logic [CNT_W-1:0] load_val;
   logic             gap_zero;
   logic [3:0]       cmd;
   boot_cfg_t        cfg;

   assign cfg = '{cas_lat:   cfg_cas_lat,
                  burst_len: cfg_burst_len,
                  burst_ilv: cfg_burst_ilv,
                  wr_single: cfg_wr_single,
                  drive:     cfg_drive,
                  pasr:      cfg_pasr};

   boot_gap_timer #(
      .CNT_W   (CNT_W),
      .RST_VAL (SETTLE_CYC - 1)
   ) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .cnt_zero (gap_zero)
   );

   boot_seq_fsm #(
      .TRP_CYC  (TRP_CYC),
      .TRC_CYC  (TRC_CYC),
      .TMRD_CYC (TMRD_CYC),
      .NUM_REF  (NUM_REF),
      .CNT_W    (CNT_W)
   ) i_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_en   (cfg_ext_en),
      .gap_zero (gap_zero),
      .phase    (phase),
      .load     (load),
      .load_val (load_val)
   );

   boot_cmd_enc #(
      .ADDR_W (ADDR_W),
      .BA_W   (BA_W)
   ) i_enc (
      .phase (phase),
      .cfg   (cfg),
      .cmd   (cmd),
      .ba    (sd_ba),
      .addr  (sd_addr),
      .ready (init_done)
   );

   assign sd_cke = 1'b1;
   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

   // precharge must address all banks (R4)
   p_pre_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_PRE) |-> sd_addr[10]);

   // a precharge is followed by a no-op gap (R5)
   p_pre_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_PRE) |=> (cmd == CMD_NOP));

   // a mode write is followed by a no-op cycle (R9)
   p_mode_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_MRS) |=> (cmd == CMD_NOP));

   // handover: bus parked while done (R9)
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (cmd == CMD_NOP && sd_addr == '0 && sd_ba == '0));

   // done never drops without reset (R10)
   p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

endmodule

// File: tb/test_sdram_boot_seq.sv
module test_sdram_boot_seq;

   localparam int CLK_PERIOD = 10;
   localparam int S    = 20;
   localparam int TRP  = 3;
   localparam int TRC  = 5;
   localparam int TMRD = 2;
   localparam int NREF = 3;

   localparam logic [3:0] C_NOP = 4'b0111;
   localparam logic [3:0] C_PRE = 4'b0010;
   localparam logic [3:0] C_REF = 4'b0001;
   localparam logic [3:0] C_MRS = 4'b0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_cas_lat = 2'd2;
   logic [2:0]  cfg_burst_len = 3'd0;
   logic        cfg_burst_ilv = 1'b0;
   logic        cfg_wr_single = 1'b0;
   logic [1:0]  cfg_drive = 2'd0;
   logic [2:0]  cfg_pasr = 3'd0;
   logic        cfg_ext_en = 1'b0;
   logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
   logic [1:0]  sd_ba;
   logic [12:0] sd_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [19:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   sdram_boot_seq #(
      .ADDR_W (13), .BA_W (2), .SETTLE_CYC (S), .TRP_CYC (TRP),
      .TRC_CYC (TRC), .TMRD_CYC (TMRD), .NUM_REF (NREF)
   ) i_sdram_boot_seq (
      .clk (clk), .rst_n (rst_n),
      .cfg_cas_lat (cfg_cas_lat), .cfg_burst_len (cfg_burst_len),
      .cfg_burst_ilv (cfg_burst_ilv), .cfg_wr_single (cfg_wr_single),
      .cfg_drive (cfg_drive), .cfg_pasr (cfg_pasr), .cfg_ext_en (cfg_ext_en),
      .sd_cke (sd_cke), .sd_cs_n (sd_cs_n), .sd_ras_n (sd_ras_n),
      .sd_cas_n (sd_cas_n), .sd_we_n (sd_we_n), .sd_ba (sd_ba),
      .sd_addr (sd_addr), .init_done (init_done)
   );

   function automatic logic [19:0] observed();
      return {init_done, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr};
   endfunction

   task automatic check_vec(input logic [19:0] exp, input string tag);
      checks++;
      if (observed() !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, observed(), exp);
      end
      checks++;
      if (sd_cke !== 1'b1) begin
         errors++;
         $display("FAIL R2 cke got %b expected 1", sd_cke);
      end
   endtask

   task automatic push(input logic r, input logic [3:0] c, input logic [1:0] b,
                       input logic [12:0] a, input string t);
      exp_q.push_back({r, c, b, a});
      tag_q.push_back(t);
   endtask

   task automatic build_model();
      logic [12:0] mw;
      logic [12:0] xw;
      mw = {3'b000, cfg_wr_single, 2'b00, 1'b0, cfg_cas_lat, cfg_burst_ilv, cfg_burst_len};
      xw = {6'b000000, cfg_drive, 2'b00, cfg_pasr};
      for (int i = 0; i < S - 1; i++) push(1'b0, C_NOP, 2'b00, 13'd0, "R3 settle");
      push(1'b0, C_PRE, 2'b00, 13'h0400, "R4 precharge");
      for (int i = 0; i < TRP - 1; i++) push(1'b0, C_NOP, 2'b00, 13'd0, "R5 tRP gap");
      for (int r = 0; r < NREF; r++) begin
         push(1'b0, C_REF, 2'b00, 13'd0, "R5 refresh");
         for (int i = 0; i < TRC - 1; i++) push(1'b0, C_NOP, 2'b00, 13'd0, "R5 tRC gap");
      end
      push(1'b0, C_MRS, 2'b00, mw, "R6 mode word");
      for (int i = 0; i < TMRD - 1; i++) push(1'b0, C_NOP, 2'b00, 13'd0, "R9 mode gap");
      if (cfg_ext_en) begin
         push(1'b0, C_MRS, 2'b10, xw, "R7 extended word");
         for (int i = 0; i < TMRD - 1; i++) push(1'b0, C_NOP, 2'b00, 13'd0, "R9 ext gap");
      end
      for (int i = 0; i < 8; i++)
         push(1'b1, C_NOP, 2'b00, 13'd0, cfg_ext_en ? "R9 R10 done held" : "R8 R10 done held");
   endtask

   // reset-state pattern: no-op, zero bus, not done
   task automatic check_reset(input string tag);
      check_vec({1'b0, C_NOP, 2'b00, 13'd0}, tag);
   endtask

   task automatic run_seq(input logic ext, input logic [1:0] cl, input logic [2:0] bl,
                          input logic ilv, input logic ws, input logic [1:0] ds,
                          input logic [2:0] pasr, input int abort_at);
      int idx;
      rst_n = 1'b0;
      cfg_ext_en = ext; cfg_cas_lat = cl; cfg_burst_len = bl; cfg_burst_ilv = ilv;
      cfg_wr_single = ws; cfg_drive = ds; cfg_pasr = pasr;
      repeat (2) @(negedge clk);
      check_reset("R1 in reset");
      exp_q.delete();
      tag_q.delete();
      build_model();
      rst_n = 1'b1;
      idx = 0;
      while (exp_q.size() > 0) begin
         @(negedge clk);
         check_vec(exp_q.pop_front(), tag_q.pop_front());
         if (idx == abort_at) begin
            rst_n = 1'b0;
            #1;
            check_reset("R10 reset during refresh");
            exp_q.delete();
            tag_q.delete();
         end
         idx++;
      end
      rst_n = 1'b0;
      #1;
      check_reset("R10 reset after done");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog got hang expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // extended write on, CL 3, length code 011, interleaved, single write, quarter array
      run_seq(1'b1, 2'd3, 3'b011, 1'b1, 1'b1, 2'b01, 3'b010, -1);
      // R8: extended write off, drive/pasr set nonzero must not appear
      run_seq(1'b0, 2'd2, 3'b111, 1'b0, 1'b0, 2'b11, 3'b001, -1);
      // R10: reset in the cycle the first refresh is on the bus
      run_seq(1'b1, 2'd1, 3'b001, 1'b0, 1'b1, 2'b10, 3'b000, S + TRP - 1);
      // full replay after abort, CL 1, half array
      run_seq(1'b1, 2'd1, 3'b000, 1'b0, 1'b0, 2'b00, 3'b001, -1);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule